// File: doc/BRIEF.md
# Serial-Loaded Gate Driver with Toggling Outputs

This block takes command frames from a three-wire serial link made of a serial clock, a data line and a frame strobe. Each frame can be protected by a single-error-correcting, double-error-detecting (SECDED) code. The accepted word drives 30 parallel gate outputs. Each output either holds a static level or inverts on a gating tick. When an output inverts for a set bit, a driver that is stuck at one level stands out as a fault. A master can also read the received stream back on an echo line and watch the decoder status.

The whole block runs on the serial clock and samples on its rising edge. The master changes the data line between rising edges and sends the most significant bit first. The frame strobe is a single-bit pulse that marks the start of the next frame. When the receiver samples that pulse, it copies the bits it has collected so far into a holding register. A four-bit mode input sets three things:
- whether frames are decoded as protected 39-bit codewords or used as raw 32-bit words;
- whether the toggling outputs step on every clock or on every second clock;
- whether the outputs show static levels or toggle.

Top module: `gateDriverTop`

## Requirements
- R1: While `rstN` is low, asynchronously and without waiting for a clock edge, `gateOut` is all zeros and `decodeStatus` is 00. The shift, holding and output registers are cleared.
- R2: Each rising edge shifts `serData` into the low end of a 39-bit shift register, so the bits of a frame arrive most significant first. A rising edge that samples `frameStrobe` high copies the shift register, as it stood before that edge, into the holding register. The holding register changes at no other time.
- R3: After each rising edge, `echoOut` equals the `serData` value sampled at that edge.
- R4: With protection off (`modeSel[0]`=0), the accepted word is bits 31:0 of the holding register. Bits 38:32 are ignored, and `decodeStatus` reads 00.
- R5: With protection on (`modeSel[0]`=1), the holding register is a codeword laid out as follows:
  - code bit p, for p from 1 to 38, sits at index p;
  - the check bits sit at indices 1, 2, 4, 8, 16 and 32, and check bit 2^j is the XOR of all data positions p that have bit j set;
  - the 32 data bits fill the remaining positions in ascending order, data bit 0 at index 3;
  - index 0 holds the XOR of bits 38:1.
  A single flipped bit at indices 1 to 38 is corrected, and `decodeStatus` reads 11.
- R6: With protection on, `decodeStatus` is 00 for a clean codeword and 01 when only index 0 is wrong. It is 10 for two flipped bits.
- R7: `gateOut[i]` is driven from bit i of the accepted word, for i from 0 to 29. The stored word is reloaded only on the rising edge after a latching edge, so sending bits without a strobe leaves the outputs unchanged.
- R8: In level mode (`modeSel[3]`=1), `gateOut` equals bits 29:0 of the stored word.
- R9: In toggle mode (`modeSel[3]`=0) with direct gating (`modeSel[1]`=0), on every rising edge each output whose stored bit is 1 inverts, and each output whose stored bit is 0 holds. The XOR of two consecutive samples therefore equals the stored word.
- R10: In toggle mode with divided gating (`modeSel[1]`=1), outputs invert on every second rising edge. Over any two consecutive edges the XOR equals the stored word, and exactly one of the two one-edge differences is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| serClk | input | 1 | Serial clock; the block samples on its rising edge |
| rstN | input | 1 | Asynchronous active-low power-on reset |
| modeSel | input | 4 | Bit 0: protection on; bit 1: divided gating; bit 2: unused; bit 3: level mode |
| serData | input | 1 | Serial data, most significant bit first |
| frameStrobe | input | 1 | One-bit pulse that latches the collected frame |
| echoOut | output | 1 | Received serial data, delayed by one edge |
| gateOut | output | 30 | Gate drive outputs |
| decodeStatus | output | 2 | Decoder result: 00 clean, 01 parity bit only, 10 double error, 11 corrected |

## Verification
The assertions check four behaviours on every cycle:
- the echo delay;
- that the holding register moves only on strobe edges;
- that level outputs move only on the edge after a latch;
- in toggle mode with direct gating, that each edge's output change equals the stored word.

Reset clearing is also checked on every cycle while reset stays low. Only the bench's scenarios show the behaviours that depend on frame content. These are:
- SECDED correction and error classification against codewords built independently in the bench;
- that the ignored upper bits have no effect with protection off;
- the two-edge stepping of divided gating.

// File: rtl/gateDriverPkg.sv
package gateDriverPkg;

  typedef struct packed {
    logic latchFrame;
    logic loadWord;
    logic gateTick;
  } ctrlStrobes_t;

  function automatic bit isPow2(input int unsigned p);
    return (p != 0) && ((p & (p - 1)) == 0);
  endfunction

endpackage

// File: rtl/secdedDecoder.sv
module secdedDecoder #(
  parameter int DATA_W = 32,
  parameter int CODE_W = 39,
  parameter int SYN_W  = 6
) (
  input  logic [CODE_W-1:0] codeIn,
  output logic [DATA_W-1:0] dataOut,
  output logic [1:0]        status
);
  import gateDriverPkg::*;

  logic [SYN_W-1:0]  syn;
  logic              parErr;
  logic [CODE_W-1:0] fixed;

  always_comb begin
    int k;
    syn    = '0;
    parErr = ^codeIn;
    for (int p = 1; p < CODE_W; p++)
      if (codeIn[p]) syn = syn ^ SYN_W'(p);
    fixed = codeIn;
    if (!parErr && syn == '0)      status = 2'b00;
    else if (parErr && syn == '0)  status = 2'b01;
    else if (parErr && int'(syn) < CODE_W) begin
      fixed[syn] = ~codeIn[syn];
      status     = 2'b11;
    end else                       status = 2'b10;
    dataOut = '0;
    k = 0;
    for (int p = 1; p < CODE_W; p++)
      if (!isPow2(p) && k < DATA_W) begin
        dataOut[k] = fixed[p];
        k++;
      end
  end

endmodule

// File: rtl/gateDriverControl.sv
module gateDriverControl
  import gateDriverPkg::*;
(
  input  logic         clk,
  input  logic         rstN,
  input  logic         frameStrobe,
  input  logic         divSel,
  output ctrlStrobes_t strobes
);
  logic loadPend;
  logic divPhase;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      loadPend <= 1'b0;
      divPhase <= 1'b0;
    end else begin
      loadPend <= frameStrobe;
      divPhase <= ~divPhase;
    end
  end

  always_comb begin
    strobes.latchFrame = frameStrobe;
    strobes.loadWord   = loadPend;
    strobes.gateTick   = divSel ? divPhase : 1'b1;
  end

endmodule

// File: rtl/gateDriverDatapath.sv
module gateDriverDatapath
  import gateDriverPkg::*;
#(
  parameter int DATA_W = 32,
  parameter int CODE_W = 39,
  parameter int SYN_W  = 6,
  parameter int GATE_N = 30
) (
  input  logic              clk,
  input  logic              rstN,
  input  ctrlStrobes_t      strobes,
  input  logic              serData,
  input  logic              protOn,
  input  logic              levelMode,
  output logic              echoOut,
  output logic [GATE_N-1:0] gateOut,
  output logic [1:0]        decodeStatus,
  output logic [CODE_W-1:0] holdWord,
  output logic [GATE_N-1:0] gateWord
);
  logic [CODE_W-1:0] shiftReg;
  logic [CODE_W-1:0] holdReg;
  logic [GATE_N-1:0] gateData;
  logic [GATE_N-1:0] togReg;
  logic [DATA_W-1:0] decData;
  logic [1:0]        decStatus;
  logic [DATA_W-1:0] acceptWord;

  secdedDecoder #(.DATA_W(DATA_W), .CODE_W(CODE_W), .SYN_W(SYN_W)) uDec (
    .codeIn (holdReg),
    .dataOut(decData),
    .status (decStatus)
  );

  assign acceptWord = protOn ? decData : holdReg[DATA_W-1:0];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      shiftReg <= '0;
      holdReg  <= '0;
      gateData <= '0;
      togReg   <= '0;
    end else begin
      shiftReg <= {shiftReg[CODE_W-2:0], serData};
      if (strobes.latchFrame) holdReg  <= shiftReg;
      if (strobes.loadWord)   gateData <= acceptWord[GATE_N-1:0];
      if (strobes.gateTick)   togReg   <= togReg ^ gateData;
    end
  end

  assign echoOut      = shiftReg[0];
  assign gateOut      = levelMode ? gateData : togReg;
  assign decodeStatus = protOn ? decStatus : 2'b00;
  assign holdWord     = holdReg;
  assign gateWord     = gateData;

endmodule

// File: rtl/gateDriverTop.sv
module gateDriverTop
  import gateDriverPkg::*;
#(
  parameter int DATA_W = 32,
  parameter int SYN_W  = 6,
  parameter int GATE_N = 30,
  localparam int CODE_W = DATA_W + SYN_W + 1
) (
  input  logic              serClk,
  input  logic              rstN,
  input  logic [3:0]        modeSel,
  input  logic              serData,
  input  logic              frameStrobe,
  output logic              echoOut,
  output logic [GATE_N-1:0] gateOut,
  output logic [1:0]        decodeStatus
);
  ctrlStrobes_t      strobes;
  logic [CODE_W-1:0] holdWord;
  logic [GATE_N-1:0] gateWord;
  logic              unusedModeBit;

  assign unusedModeBit = modeSel[2];

  gateDriverControl uCtrl (
    .clk        (serClk),
    .rstN       (rstN),
    .frameStrobe(frameStrobe),
    .divSel     (modeSel[1]),
    .strobes    (strobes)
  );

  gateDriverDatapath #(
    .DATA_W(DATA_W), .CODE_W(CODE_W), .SYN_W(SYN_W), .GATE_N(GATE_N)
  ) uPath (
    .clk         (serClk),
    .rstN        (rstN),
    .strobes     (strobes),
    .serData     (serData),
    .protOn      (modeSel[0]),
    .levelMode   (modeSel[3]),
    .echoOut     (echoOut),
    .gateOut     (gateOut),
    .decodeStatus(decodeStatus),
    .holdWord    (holdWord),
    .gateWord    (gateWord)
  );

endmodule

// File: rtl/gateDriverChecker.sv
module gateDriverChecker #(
  parameter int CODE_W = 39,
  parameter int GATE_N = 30
) (
  input logic              serClk,
  input logic              rstN,
  input logic [3:0]        modeSel,
  input logic              serData,
  input logic              frameStrobe,
  input logic              echoOut,
  input logic [GATE_N-1:0] gateOut,
  input logic [1:0]        decodeStatus,
  input logic [CODE_W-1:0] holdWord,
  input logic [GATE_N-1:0] gateWord
);

  p_reset_clear_r1: assert property (@(posedge serClk)
    (!$past(rstN) && !rstN) |-> (gateOut == '0 && decodeStatus == 2'b00 && holdWord == '0));

  p_hold_only_on_strobe_r2: assert property (@(posedge serClk) disable iff (!rstN)
    ($past(rstN) && !$past(frameStrobe)) |-> $stable(holdWord));

  p_echo_delay_r3: assert property (@(posedge serClk) disable iff (!rstN)
    $past(rstN) |-> echoOut == $past(serData));

  p_level_stable_r7: assert property (@(posedge serClk) disable iff (!rstN)
    ($past(rstN) && $past(rstN, 2) && modeSel[3] && $past(modeSel[3]) && !$past(frameStrobe, 2))
      |-> $stable(gateOut));

  p_toggle_step_r9: assert property (@(posedge serClk) disable iff (!rstN)
    ($past(rstN) && !modeSel[3] && !$past(modeSel[3]) && !$past(modeSel[1]))
      |-> ((gateOut ^ $past(gateOut)) == $past(gateWord)));

endmodule

bind gateDriverTop gateDriverChecker #(.CODE_W(CODE_W), .GATE_N(GATE_N)) uChk (
  .serClk      (serClk),
  .rstN        (rstN),
  .modeSel     (modeSel),
  .serData     (serData),
  .frameStrobe (frameStrobe),
  .echoOut     (echoOut),
  .gateOut     (gateOut),
  .decodeStatus(decodeStatus),
  .holdWord    (holdWord),
  .gateWord    (gateWord)
);

// File: tb/tb_gateDriverTop.sv
`timescale 1ns/1ps
module tb_gateDriverTop;

  logic        serClk = 1'b0;
  logic        rstN = 1'b0;
  logic [3:0]  modeSel = 4'b0000;
  logic        serData = 1'b0;
  logic        frameStrobe = 1'b0;
  logic        echoOut;
  logic [29:0] gateOut;
  logic [1:0]  decodeStatus;

  int checks = 0;
  int failures = 0;

  always #2 serClk = ~serClk;

  gateDriverTop dut (
    .serClk(serClk), .rstN(rstN), .modeSel(modeSel), .serData(serData),
    .frameStrobe(frameStrobe), .echoOut(echoOut), .gateOut(gateOut),
    .decodeStatus(decodeStatus)
  );

  typedef struct packed {
    logic        prot;
    logic        level;
    logic        divd;
    logic [31:0] data;
    logic [6:0]  flipA;
    logic [6:0]  flipB;
    logic [1:0]  expSt;
  } vecT;

  localparam logic [6:0] NONE = 7'd127;
  localparam vecT TBL [8] = '{
    '{1'b0, 1'b1, 1'b0, 32'h1234_5678, NONE,  NONE,  2'b00},
    '{1'b0, 1'b0, 1'b0, 32'hC0F0_A5A5, NONE,  NONE,  2'b00},
    '{1'b0, 1'b0, 1'b1, 32'h3FFF_FFFF, NONE,  NONE,  2'b00},
    '{1'b1, 1'b1, 1'b0, 32'hDEAD_BEEF, NONE,  NONE,  2'b00},
    '{1'b1, 1'b1, 1'b0, 32'h0F0F_1234, 7'd7,  NONE,  2'b11},
    '{1'b1, 1'b0, 1'b0, 32'h2AAA_AAAA, 7'd0,  NONE,  2'b01},
    '{1'b1, 1'b1, 1'b0, 32'h1111_2222, 7'd3,  7'd20, 2'b10},
    '{1'b1, 1'b0, 1'b1, 32'h0000_0001, 7'd38, NONE,  2'b11}
  };

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [38:0] encode(input logic [31:0] d);
    logic [38:0] w;
    logic [5:0]  s;
    int k;
    w = '0; k = 0; s = '0;
    for (int p = 1; p < 39; p++)
      if ((p & (p - 1)) != 0) begin
        w[p] = d[k];
        if (d[k]) s = s ^ 6'(p);
        k++;
      end
    for (int j = 0; j < 6; j++) w[1 << j] = s[j];
    w[0] = ^w[38:1];
    return w;
  endfunction

  task automatic deliver(input logic [38:0] frame, input int len);
    for (int i = len - 1; i >= 0; i--) begin
      @(negedge serClk);
      serData = frame[i];
      frameStrobe = 1'b0;
    end
    @(negedge serClk);
    serData = 1'b0;
    frameStrobe = 1'b1;
    @(negedge serClk);
    frameStrobe = 1'b0;
  endtask

  initial begin
    #400000;
    failures++;
    $display("FAIL watchdog actual=hung expected=finished");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    logic [38:0] frame;
    logic [29:0] a, m, b;
    repeat (3) @(negedge serClk);
    chk("R1 gate in reset", 64'(gateOut), 64'h0);
    chk("R1 status in reset", 64'(decodeStatus), 64'h0);
    rstN = 1'b1;

    // R3 echo of serial data
    for (int i = 0; i < 4; i++) begin
      @(negedge serClk);
      serData = i[0] ^ i[1];
      @(negedge serClk);
      chk("R3 echo", 64'(echoOut), 64'(i[0] ^ i[1]));
    end

    // vector table: R2 R4 R5 R6 R7 R8 R9 R10
    foreach (TBL[n]) begin
      vecT v;
      v = TBL[n];
      modeSel = {v.level, 1'b0, v.divd, v.prot};
      if (v.prot) begin
        frame = encode(v.data);
        if (v.flipA != NONE) frame[v.flipA] = ~frame[v.flipA];
        if (v.flipB != NONE) frame[v.flipB] = ~frame[v.flipB];
      end else frame = {7'b0, v.data};
      deliver(frame, v.prot ? 39 : 32);
      @(negedge serClk);
      @(negedge serClk);
      chk(v.prot ? "R5 R6 status" : "R4 status off", 64'(decodeStatus), 64'(v.expSt));
      if (v.expSt != 2'b10) begin
        if (v.level) begin
          chk("R2 R7 R8 level outputs", 64'(gateOut), 64'(v.data[29:0]));
        end else if (!v.divd) begin
          a = gateOut;
          @(negedge serClk);
          b = gateOut;
          chk("R9 toggle direct xor", 64'(a ^ b), 64'(v.data[29:0]));
        end else begin
          a = gateOut;
          @(negedge serClk);
          m = gateOut;
          @(negedge serClk);
          b = gateOut;
          chk("R10 divided two-edge xor", 64'(a ^ b), 64'(v.data[29:0]));
          chk("R10 one edge idle", 64'(((a ^ m) == 30'h0) != ((m ^ b) == 30'h0)), 64'd1);
        end
      end
    end

    // R4: upper bits ignored with protection off
    modeSel = 4'b1000;
    deliver({7'h7F, 32'h0000_5A5A}, 39);
    repeat (2) @(negedge serClk);
    chk("R4 upper bits ignored", 64'(gateOut), 64'h5A5A);
    chk("R4 status 00", 64'(decodeStatus), 64'h0);

    // R7: bits without strobe leave outputs alone
    for (int i = 31; i >= 0; i--) begin
      @(negedge serClk);
      serData = i[0];
    end
    repeat (2) @(negedge serClk);
    chk("R7 no strobe no change", 64'(gateOut), 64'h5A5A);

    // R1: asynchronous reset mid-run
    modeSel = 4'b1001;
    deliver(encode(32'h0F0F_1234) ^ 39'h80, 39);
    repeat (2) @(negedge serClk);
    #1 rstN = 1'b0;
    #0.5;
    chk("R1 async clear gate", 64'(gateOut), 64'h0);
    chk("R1 async clear status", 64'(decodeStatus), 64'h0);
    @(negedge serClk);
    rstN = 1'b1;
    @(negedge serClk);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule